// File: doc/BRIEF.md
# Bulk IN Endpoint Dual-Bank Transmit Buffer

This block holds outgoing packet data for one bulk IN endpoint in two banks of equal size. A producer, either software or a DMA engine, streams 32-bit words into the bank currently being filled. Writing a byte count to the packet-commit input freezes that bank as one pending packet and moves filling to the other bank. This lets the producer prepare the next packet while the previous one is still waiting for the host.

On the serial side, an IN token is answered in one of three ways. If no bank is pending, the block raises NAK. If the oldest pending packet has length zero, it signals a zero-length packet. Otherwise it streams the oldest pending packet out one byte at a time. A bank stays pending until the host acknowledges it. A timeout leaves the bank in place, so the next token resends the same data. A clear input drops every pending packet and returns both sides to bank 0.

The write port is valid/ready: a word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops when the fill bank already holds a full bank of words, or when the fill bank is still pending because both banks hold packets. A word taken in the same cycle as an accepted commit lands in the bank being committed. The byte port is also valid/ready: while `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values. Packet bytes leave in ascending address order. Within each stored word the least significant byte goes first.

Top module: `inep_pp_buf`

## Requirements
- R1: After reset, `wr_ready` is 1 and `tx_valid`, `rsp_nak`, `rsp_zlp` and `ovf_flag` are 0.
- R2: Accepted words fill the current bank in order. `wr_ready` goes low once that bank holds BANK_BYTES/4 words (128 by default), and stays low while the fill bank is pending.
- R3: A commit when the fill bank is free makes that bank pending with the given length and moves filling to the other bank, starting at word 0.
- R4: A commit while both banks are pending changes nothing else and sets `ovf_flag`. The flag then stays high until a clear.
- R5: An IN token when no bank is pending raises `rsp_nak` for exactly the next cycle. A token that arrives while a packet is being sent or awaits its handshake is ignored.
- R6: An IN token with a pending packet of nonzero length streams that packet's bytes from the oldest pending bank, starting in the next cycle. Bytes come least significant first within each word, the count equals the stored length, and `tx_last` marks the final byte.
- R7: A pending packet of length 0 answers a token with a one-cycle `rsp_zlp` pulse in the next cycle and no `tx_valid`.
- R8: `hs_ack` after a packet frees its bank, so the next token sends the other bank. `hs_timeout` keeps the bank pending, so the next token resends the same bytes.
- R9: `clr` drops both pending packets, clears `ovf_flag` and resets both bank pointers. A following token gets NAK.
- R10: A committed length above BANK_BYTES is stored as BANK_BYTES.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Drop all pending packets and reset pointers |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Fill bank can take a word |
| wr_data | input | WORD_W | Packet data word |
| pkt_commit | input | 1 | Commit fill bank as a packet |
| pkt_len | input | LEN_W | Packet byte count for the commit |
| ovf_flag | output | 1 | Sticky flag: commit refused with both banks pending |
| in_token | input | 1 | IN token received for this endpoint |
| rsp_nak | output | 1 | Answer NAK to the current token |
| rsp_zlp | output | 1 | Answer with a zero-length packet |
| tx_valid | output | 1 | Packet byte valid |
| tx_ready | input | 1 | Byte consumer ready |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| hs_ack | input | 1 | Host acknowledged the last packet |
| hs_timeout | input | 1 | No handshake arrived for the last packet |

## Verification
The hardest state to reach is both banks pending with a third commit arriving. The bench gets there by committing two packets back to back without issuing any token. It then checks that the refused commit altered neither packet, by draining both packets and comparing every byte. Resend after a timeout is reached by withholding the acknowledgement and issuing a second token. The bench also sweeps packet lengths around every word boundary and both bank-size limits, including an oversized length. Meanwhile the byte consumer pauses on a repeating pattern, so both bank alternation and back-pressure are exercised at every length.

// File: rtl/ipp_pkg.sv
package ipp_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ipp_bank_mem.sv
module ipp_bank_mem #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 128,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wbank,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rbank,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] rd_b [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem [WORDS];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else if (we && (wbank == 1'(b))) begin
        mem[waddr] <= wdata;
      end
    end
    assign rd_b[b] = mem[raddr];
  end

  assign rdata = rd_b[rbank];
endmodule

// File: rtl/ipp_fill_ctrl.sv
module ipp_fill_ctrl #(
  parameter int WORDS = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          fill_valid,
  input  logic          commit_ok,
  output logic          fill_bank,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr
);
  logic [AW:0] ptr;

  assign wr_ready = !fill_valid && (ptr < (AW+1)'(WORDS));
  assign mem_we   = wr_valid && wr_ready;
  assign mem_addr = ptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      fill_bank <= 1'b0;
    end else if (clr) begin
      ptr       <= '0;
      fill_bank <= 1'b0;
    end else if (commit_ok) begin
      ptr       <= '0;
      fill_bank <= ~fill_bank;
    end else if (mem_we) begin
      ptr <= ptr + 1'b1;
    end
  end

  p_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok && !clr |=> (fill_bank != $past(fill_bank)) && (ptr == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !commit_ok && !clr |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/ipp_bank_track.sv
module ipp_bank_track #(
  parameter int BANK_BYTES = 512,
  parameter int LEN_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             commit,
  input  logic [LEN_W-1:0] commit_len,
  input  logic             fill_bank,
  input  logic             free_pulse,
  input  logic             send_bank,
  output logic [1:0]       bank_valid,
  output logic [LEN_W-1:0] send_len,
  output logic             commit_ok,
  output logic             ovf_flag
);
  logic [LEN_W-1:0] len_q [2];
  logic [LEN_W-1:0] capped;

  assign commit_ok = commit && !bank_valid[fill_bank];
  assign capped    = (commit_len > LEN_W'(BANK_BYTES)) ? LEN_W'(BANK_BYTES) : commit_len;
  assign send_len  = len_q[send_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_valid <= '0;
      ovf_flag   <= 1'b0;
      for (int i = 0; i < 2; i++) len_q[i] <= '0;
    end else if (clr) begin
      bank_valid <= '0;
      ovf_flag   <= 1'b0;
    end else begin
      if (commit_ok) begin
        bank_valid[fill_bank] <= 1'b1;
        len_q[fill_bank]      <= capped;
      end
      if (free_pulse) bank_valid[send_bank] <= 1'b0;
      if (commit && !commit_ok) ovf_flag <= 1'b1;
    end
  end

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !clr |=> ovf_flag);
  p_commit_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok && !clr && !free_pulse |=> bank_valid[$past(fill_bank)]);
  p_len_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    send_len <= LEN_W'(BANK_BYTES));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> bank_valid == 2'b00 && !ovf_flag);
endmodule

// File: rtl/ipp_tx_engine.sv
module ipp_tx_engine
  import ipp_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int BANK_BYTES = 512,
  parameter int LEN_W      = 10,
  parameter int BSEL       = 2,
  parameter int AW         = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_token,
  input  logic [1:0]        bank_valid,
  input  logic [LEN_W-1:0]  send_len,
  output logic              send_bank,
  output logic              free_pulse,
  output logic              rsp_nak,
  output logic              rsp_zlp,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic [WORD_W-1:0] rd_word,
  output logic [AW-1:0]     rd_addr,
  input  logic              hs_ack,
  input  logic              hs_timeout
);
  tx_state_e        state;
  logic [LEN_W-1:0] cnt;
  logic             cur_valid;

  assign cur_valid  = bank_valid[send_bank];
  assign tx_valid   = (state == TX_SEND);
  assign tx_last    = tx_valid && (cnt == send_len - LEN_W'(1));
  assign tx_data    = rd_word[{cnt[BSEL-1:0], 3'b000} +: 8];
  assign rd_addr    = cnt[BSEL+AW-1:BSEL];
  assign free_pulse = (state == TX_WAIT) && hs_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      cnt       <= '0;
      send_bank <= 1'b0;
      rsp_nak   <= 1'b0;
      rsp_zlp   <= 1'b0;
    end else if (clr) begin
      state     <= TX_IDLE;
      cnt       <= '0;
      send_bank <= 1'b0;
      rsp_nak   <= 1'b0;
      rsp_zlp   <= 1'b0;
    end else begin
      rsp_nak <= 1'b0;
      rsp_zlp <= 1'b0;
      unique case (state)
        TX_IDLE: begin
          if (in_token) begin
            if (!cur_valid) begin
              rsp_nak <= 1'b1;
            end else if (send_len == '0) begin
              rsp_zlp <= 1'b1;
              state   <= TX_WAIT;
            end else begin
              cnt   <= '0;
              state <= TX_SEND;
            end
          end
        end
        TX_SEND: begin
          if (tx_ready) begin
            cnt <= cnt + 1'b1;
            if (tx_last) state <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          if (hs_ack) begin
            send_bank <= ~send_bank;
            state     <= TX_IDLE;
          end else if (hs_timeout) begin
            state <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !clr |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  p_nak_after_token_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nak |-> $past(in_token));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_nak, rsp_zlp, tx_valid}));
  p_zlp_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_zlp |-> !tx_valid && state == TX_WAIT);
  p_hold_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !free_pulse && !clr |=> $stable(send_bank));
  p_cnt_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LEN_W'(BANK_BYTES));
endmodule

// File: rtl/inep_pp_buf.sv
module inep_pp_buf #(
  parameter int WORD_W     = 32,
  parameter int BANK_BYTES = 512,
  localparam int LEN_W     = $clog2(BANK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pkt_commit,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              ovf_flag,
  input  logic              in_token,
  output logic              rsp_nak,
  output logic              rsp_zlp,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              hs_ack,
  input  logic              hs_timeout
);
  localparam int BPW   = WORD_W / 8;
  localparam int BSEL  = $clog2(BPW);
  localparam int WORDS = BANK_BYTES / BPW;
  localparam int AW    = $clog2(WORDS);

  logic              fill_bank, send_bank, commit_ok, free_pulse, mem_we;
  logic [1:0]        bank_valid;
  logic [LEN_W-1:0]  send_len;
  logic [AW-1:0]     waddr, raddr;
  logic [WORD_W-1:0] rd_word;

  ipp_fill_ctrl #(.WORDS(WORDS), .AW(AW)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .fill_valid(bank_valid[fill_bank]), .commit_ok(commit_ok), .fill_bank(fill_bank),
    .mem_we(mem_we), .mem_addr(waddr));

  ipp_bank_track #(.BANK_BYTES(BANK_BYTES), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(clr), .commit(pkt_commit), .commit_len(pkt_len),
    .fill_bank(fill_bank), .free_pulse(free_pulse), .send_bank(send_bank),
    .bank_valid(bank_valid), .send_len(send_len), .commit_ok(commit_ok), .ovf_flag(ovf_flag));

  ipp_bank_mem #(.WORD_W(WORD_W), .WORDS(WORDS), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .wbank(fill_bank), .waddr(waddr),
    .wdata(wr_data), .rbank(send_bank), .raddr(raddr), .rdata(rd_word));

  ipp_tx_engine #(.WORD_W(WORD_W), .BANK_BYTES(BANK_BYTES), .LEN_W(LEN_W),
                  .BSEL(BSEL), .AW(AW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_token(in_token), .bank_valid(bank_valid),
    .send_len(send_len), .send_bank(send_bank), .free_pulse(free_pulse),
    .rsp_nak(rsp_nak), .rsp_zlp(rsp_zlp), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .rd_word(rd_word), .rd_addr(raddr),
    .hs_ack(hs_ack), .hs_timeout(hs_timeout));

  p_ready_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !bank_valid[fill_bank]);
  p_nak_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nak |-> $past(bank_valid) == 2'b00 || $past(clr));
endmodule

// File: tb/inep_pp_buf_bench.sv
module inep_pp_buf_bench;
  localparam int LW = 10;
  logic clk = 0, rst_n = 0;
  logic clr = 0, wr_valid = 0, pkt_commit = 0, in_token = 0, tx_ready = 0;
  logic hs_ack = 0, hs_timeout = 0;
  logic [31:0] wr_data = '0;
  logic [LW-1:0] pkt_len = '0;
  logic wr_ready, ovf_flag, rsp_nak, rsp_zlp, tx_valid, tx_last;
  logic [7:0] tx_data;
  int checks = 0, errors = 0, step = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  inep_pp_buf u_inep_pp_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .pkt_commit(pkt_commit), .pkt_len(pkt_len), .ovf_flag(ovf_flag),
    .in_token(in_token), .rsp_nak(rsp_nak), .rsp_zlp(rsp_zlp), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .hs_ack(hs_ack),
    .hs_timeout(hs_timeout));

  function automatic logic [31:0] pat(int pkt, int i);
    return 32'(pkt * 32'h01000193 + i * 32'h9E3779B9 + 32'h5A);
  endfunction

  function automatic logic [7:0] exp_byte(int pkt, int j);
    logic [31:0] w = pat(pkt, j / 4);
    return w[8*(j%4) +: 8];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic push_words(int pkt, int n);
    int i = 0;
    while (i < n) begin
      wr_valid = 1; wr_data = pat(pkt, i);
      if (wr_ready) i++;
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic commit(int len);
    pkt_commit = 1; pkt_len = LW'(len);
    @(negedge clk);
    pkt_commit = 0;
  endtask

  task automatic token();
    in_token = 1;
    @(negedge clk);
    in_token = 0;
  endtask

  task automatic pulse_ack();
    hs_ack = 1; @(negedge clk); hs_ack = 0;
  endtask

  // token, then receive a packet of explen bytes carrying pattern pkt
  task automatic fetch(int pkt, int explen);
    int j = 0;
    logic [7:0] held;
    token();
    if (explen == 0) begin
      chk(rsp_zlp == 1'b1, "R7 zlp pulse", int'(rsp_zlp), 1);
      chk(tx_valid == 1'b0, "R7 no data", int'(tx_valid), 0);
      @(negedge clk);
      chk(rsp_zlp == 1'b0, "R7 zlp one cycle", int'(rsp_zlp), 0);
      return;
    end
    while (j < explen) begin
      tx_ready = ((step++ % 3) != 2);
      chk(tx_valid == 1'b1, "R6 valid during packet", int'(tx_valid), 1);
      if (!tx_ready) begin
        held = tx_data;
        @(negedge clk);
        chk(tx_data == held, "R11 hold under back-pressure", int'(tx_data), int'(held));
      end else begin
        chk(tx_data == exp_byte(pkt, j), "R6 byte", int'(tx_data), int'(exp_byte(pkt, j)));
        chk(tx_last == (j == explen - 1), "R6 last", int'(tx_last), int'(j == explen - 1));
        j++;
        @(negedge clk);
      end
    end
    tx_ready = 0;
    chk(tx_valid == 1'b0, "R6 byte count ends", int'(tx_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wr_ready == 1, "R1 wr_ready", int'(wr_ready), 1);
    chk(tx_valid == 0 && rsp_nak == 0 && rsp_zlp == 0, "R1 outputs idle",
        int'({tx_valid, rsp_nak, rsp_zlp}), 0);
    chk(ovf_flag == 0, "R1 ovf", int'(ovf_flag), 0);

    // R5: empty endpoint naks, for exactly one cycle
    token();
    chk(rsp_nak == 1, "R5 nak on empty", int'(rsp_nak), 1);
    @(negedge clk);
    chk(rsp_nak == 0, "R5 nak one cycle", int'(rsp_nak), 0);

    // length sweep with alternating banks; R10 with oversize length
    foreach (lens_q[k]) begin
      int L = lens_q[k];
      int eff = (L > 512) ? 512 : L;
      int nw = (eff + 3) / 4;
      push_words(100 + k, nw);
      if (nw == 128)
        chk(wr_ready == 0, "R2 bank full blocks", int'(wr_ready), 0);
      commit(L);
      chk(wr_ready == 1, "R3 fill moved to free bank", int'(wr_ready), 1);
      fetch(100 + k, eff);
      // R5: token while waiting for handshake is ignored
      token();
      chk(rsp_nak == 0 && rsp_zlp == 0 && tx_valid == 0, "R5 token ignored when busy",
          int'({rsp_nak, rsp_zlp, tx_valid}), 0);
      pulse_ack();
    end
    token();
    chk(rsp_nak == 1, "R8 ack freed bank", int'(rsp_nak), 1);

    // R4: two pending, third commit refused
    push_words(7, 3); commit(11);
    push_words(8, 5); commit(18);
    chk(wr_ready == 0, "R2 fill bank pending blocks", int'(wr_ready), 0);
    chk(ovf_flag == 0, "R4 no ovf yet", int'(ovf_flag), 0);
    commit(4);
    chk(ovf_flag == 1, "R4 ovf set", int'(ovf_flag), 1);
    // R8: timeout resends same bank
    fetch(7, 11);
    hs_timeout = 1; @(negedge clk); hs_timeout = 0;
    fetch(7, 11);
    pulse_ack();
    chk(wr_ready == 1, "R2 freed bank writable", int'(wr_ready), 1);
    fetch(8, 18);
    pulse_ack();
    chk(ovf_flag == 1, "R4 ovf sticky", int'(ovf_flag), 1);

    // R9: clear drops pending packets
    push_words(9, 2); commit(8);
    push_words(10, 2); commit(8);
    commit(1);
    clr = 1; @(negedge clk); clr = 0;
    chk(ovf_flag == 0, "R9 ovf cleared", int'(ovf_flag), 0);
    chk(wr_ready == 1, "R9 fill writable", int'(wr_ready), 1);
    token();
    chk(rsp_nak == 1, "R9 nak after clear", int'(rsp_nak), 1);
    push_words(11, 1); commit(3);
    fetch(11, 3);
    pulse_ack();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int lens_q [20] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 15, 16, 17, 63, 129, 255, 256, 511, 512, 700};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule